// File: doc/BRIEF.md
# No-Turnaround Synchronous SRAM Core

A single-clock synchronous static memory that accepts a read or a write on every rising edge, in any mix, without deselect cycles when the bus direction changes. Address, direction, byte enables, chip selects and the burst-advance control are all registered on the rising edge. Write data follows its address by a fixed number of edges (late write), and the memory resolves the resulting read-after-write hazards on its own. The host therefore streams reads and writes with no gaps and never tracks which writes are still in flight.

A static mode input selects between a registered read path (two-edge read latency, write data two edges late) and an unregistered read path (one-edge read latency, write data one edge late). A started access can be extended into a four-beat burst whose address sequence is either a counting sequence or an XOR sequence. Output enable and sleep act on the data drivers at once, without waiting for a clock edge. Sleep also stops any new access from being accepted.

Top module: `nt_sram`

## Requirements
- R1: A read or a write may be started on every rising edge, in any order, including a write directly after a read and a read directly after a write, with no idle edge between them.
- R2: For a write sampled at edge k, the bytes on `dq_in` are taken at edge k+2 when `pipe_mode`=1 and at edge k+1 when `pipe_mode`=0.
- R3: For a read sampled at edge k, the word is driven on `dq_out` with `dq_oe`=1 during the cycle after edge k+2 when `pipe_mode`=1, and during the cycle after edge k+1 when `pipe_mode`=0.
- R4: A read returns the most recent data written to its address, even when that write's data has not yet reached the array. Bytes the pending write did not enable keep their earlier value.
- R5: A new access starts only when `adv`=0, `sel_a_n`=0, `sel_b`=1 and `sel_c_n`=0. With `adv`=0 and any select inactive, the edge is a deselect: no array change, no driven output, and any burst ends.
- R6: With `adv`=1 after a started access, the next beat repeats the burst's direction at the next burst address. The select inputs are ignored on such edges. With `lin_order`=1 the two low address bits count up by one modulo 4 from the start address.
- R7: With `lin_order`=0, the two low address bits of beat n (n=0..3) equal the start address's low bits XOR n.
- R8: The address bits above bit 1 stay those of the start address for all beats. After four beats, further `adv` edges wrap to beat 0 of the same four-word block.
- R9: `bw_n` has one active-low bit per 9-bit byte: bit b covers `dq_in[9b+8:9b]`. It is sampled at the same edge as each beat's address, and bytes whose bit is 1 are not changed.
- R10: `oe_n`=1 forces `dq_oe` low immediately and does not disturb reads in flight.
- R11: While `sleep`=1, `dq_oe` is low, no access or burst beat is accepted, any burst ends, and the array contents are kept.
- R12: After reset, and in every cycle that carries no read data, `dq_oe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| pipe_mode | input | 1 | 1 = registered read path, 0 = unregistered read path (static) |
| addr | input | 6 | Word address of a new access |
| wr_sel | input | 1 | 1 = write, 0 = read, for a new access |
| bw_n | input | 2 | Active-low byte write enables, one per 9-bit byte |
| sel_a_n | input | 1 | Chip select, active low |
| sel_b | input | 1 | Chip select, active high |
| sel_c_n | input | 1 | Chip select, active low |
| adv | input | 1 | 1 = continue the current burst |
| lin_order | input | 1 | Burst order: 1 = counting, 0 = XOR (static) |
| oe_n | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Asynchronous power-down request |
| dq_in | input | 18 | Write data from the bidirectional bus |
| dq_out | output | 18 | Read data toward the bidirectional bus |
| dq_oe | output | 1 | Drive enable for `dq_out` |

## Verification
The assertions assume that `pipe_mode` and `lin_order` are constant between resets, and that `dq_in` carries the intended data at the edge a write's data is due. The stimulus only changes `pipe_mode` while reset is asserted, and it changes `lin_order` only on idle edges between bursts. Write data is placed on `dq_in` from a schedule keyed by the edge at which the memory will take it. Sleep and output enable are driven between edges, and the bench expects them to blank the output in the same cycle.

// File: rtl/nt_pkg.sv
package nt_pkg;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } op_kind_e;

  // Low two address bits of a burst beat.
  function automatic logic [1:0] beat_low(input logic [1:0] start,
                                          input logic [1:0] beat,
                                          input logic       linear);
    logic [1:0] res;
    if (linear) res = start + beat;
    else        res = start ^ beat;
    return res;
  endfunction

endpackage

// File: rtl/nt_burst_seq.sv
module nt_burst_seq
  import nt_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int NBYTES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_ok,
  input  logic              adv,
  input  logic              sleep,
  input  logic              wr_req,
  input  logic              lin_order,
  input  logic [ADDR_W-1:0] addr,
  input  logic [NBYTES-1:0] bw_n,
  output op_kind_e          iss_kind,
  output logic [ADDR_W-1:0] iss_addr,
  output logic [NBYTES-1:0] iss_bw_n
);

  localparam int HI_W = ADDR_W - 2;

  logic              act_q, act_d;
  logic              wr_q, wr_d;
  logic [1:0]        cnt_q, cnt_d;
  logic [1:0]        nxt_cnt;
  logic [ADDR_W-1:0] base_q;
  logic              start, cont;

  always_comb begin
    nxt_cnt  = cnt_q + 2'd1;
    start    = !sleep && !adv && sel_ok;
    cont     = !sleep && adv && act_q;
    iss_kind = OP_IDLE;
    iss_addr = addr;
    iss_bw_n = bw_n;
    act_d    = act_q;
    wr_d     = wr_q;
    cnt_d    = cnt_q;
    if (start) begin
      iss_kind = wr_req ? OP_WRITE : OP_READ;
      act_d    = 1'b1;
      wr_d     = wr_req;
      cnt_d    = 2'd0;
    end else if (cont) begin
      iss_kind = wr_q ? OP_WRITE : OP_READ;
      iss_addr = {base_q[ADDR_W-1:2], beat_low(base_q[1:0], nxt_cnt, lin_order)};
      cnt_d    = nxt_cnt;
    end else if (sleep || !adv) begin
      act_d    = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      wr_q  <= 1'b0;
      cnt_q <= 2'd0;
    end else begin
      act_q <= act_d;
      wr_q  <= wr_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (start) base_q <= addr;
  end

  AST_BURST_SAME_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    cont |-> iss_addr[ADDR_W-1:2] == $past(iss_addr[ADDR_W-1:2])); // R8

  AST_LINEAR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (cont && lin_order && $past(lin_order)) |-> iss_addr[1:0] == $past(iss_addr[1:0]) + 2'd1); // R6

  AST_XOR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (cont && !lin_order && !$past(lin_order)) |->
      (iss_addr[1:0] ^ $past(iss_addr[1:0])) == (nxt_cnt[0] ? 2'd1 : 2'd3)); // R7

  logic [HI_W-1:0] unused_hi;
  assign unused_hi = base_q[ADDR_W-1:2];

endmodule

// File: rtl/nt_mem_array.sv
module nt_mem_array #(
  parameter int ADDR_W = 6,
  parameter int NBYTES = 2,
  parameter int BYTE_W = 9
) (
  input  logic                     clk,
  input  logic                     we,
  input  logic [ADDR_W-1:0]        wa,
  input  logic [NBYTES-1:0]        wbe,
  input  logic [NBYTES*BYTE_W-1:0] wd,
  input  logic [ADDR_W-1:0]        ra,
  output logic [NBYTES*BYTE_W-1:0] rd
);

  localparam int DEPTH = 1 << ADDR_W;

  for (genvar b = 0; b < NBYTES; b++) begin : g_lane
    logic [BYTE_W-1:0] lane [DEPTH];

    always_ff @(posedge clk) begin
      if (we && wbe[b]) lane[wa] <= wd[b*BYTE_W +: BYTE_W];
    end

    assign rd[b*BYTE_W +: BYTE_W] = lane[ra];
  end

endmodule

// File: rtl/nt_xfer_pipe.sv
module nt_xfer_pipe
  import nt_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int NBYTES = 2,
  parameter int BYTE_W = 9
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     pipe_mode,
  input  logic                     oe_n,
  input  logic                     sleep,
  input  op_kind_e                 iss_kind,
  input  logic [ADDR_W-1:0]        iss_addr,
  input  logic [NBYTES-1:0]        iss_bw_n,
  input  logic [NBYTES*BYTE_W-1:0] dq_in,
  input  logic [NBYTES*BYTE_W-1:0] mem_rd,
  output logic [ADDR_W-1:0]        mem_ra,
  output logic                     mem_we,
  output logic [ADDR_W-1:0]        mem_wa,
  output logic [NBYTES-1:0]        mem_wbe,
  output logic [NBYTES*BYTE_W-1:0] mem_wd,
  output logic [NBYTES*BYTE_W-1:0] dq_out,
  output logic                     dq_oe
);

  localparam int DATA_W = NBYTES * BYTE_W;

  // Stage 1: op seen at the last edge. Stage 2: op of the edge before.
  op_kind_e          s1_kind, s2_kind;
  logic [ADDR_W-1:0] s1_addr, s2_addr;
  logic [NBYTES-1:0] s1_bw_n, s2_bw_n;
  logic              s3_rd;

  logic [DATA_W-1:0] rd_q, out_q;
  logic [DATA_W-1:0] merged;
  logic              hit, rd_load, out_load, drive_slot;

  // Late-write commit point depends on the read mode.
  always_comb begin
    if (pipe_mode) begin
      mem_we  = (s2_kind == OP_WRITE);
      mem_wa  = s2_addr;
      mem_wbe = ~s2_bw_n;
    end else begin
      mem_we  = (s1_kind == OP_WRITE);
      mem_wa  = s1_addr;
      mem_wbe = ~s1_bw_n;
    end
    mem_wd   = dq_in;
    mem_ra   = s1_addr;
    hit      = mem_we && (mem_wa == s1_addr);
    rd_load  = (s1_kind == OP_READ);
    out_load = (s2_kind == OP_READ);
  end

  // Forward bytes of a write that commits at the same edge as the read.
  for (genvar b = 0; b < NBYTES; b++) begin : g_fwd
    assign merged[b*BYTE_W +: BYTE_W] = (hit && mem_wbe[b]) ? dq_in[b*BYTE_W +: BYTE_W]
                                                           : mem_rd[b*BYTE_W +: BYTE_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_kind <= OP_IDLE;
      s2_kind <= OP_IDLE;
      s3_rd   <= 1'b0;
    end else begin
      s1_kind <= iss_kind;
      s2_kind <= s1_kind;
      s3_rd   <= (s2_kind == OP_READ);
    end
  end

  always_ff @(posedge clk) begin
    s1_addr <= iss_addr;
    s1_bw_n <= iss_bw_n;
    s2_addr <= s1_addr;
    s2_bw_n <= s1_bw_n;
  end

  always_ff @(posedge clk) begin
    if (rd_load)  rd_q  <= merged;
    if (out_load) out_q <= rd_q;
  end

  always_comb begin
    drive_slot = pipe_mode ? s3_rd : (s2_kind == OP_READ);
    dq_out     = pipe_mode ? out_q : rd_q;
    dq_oe      = drive_slot && !oe_n && !sleep;
  end

  AST_PIPE_WRITE_LAG: assert property (@(posedge clk) disable iff (!rst_n)
    (pipe_mode && $past(pipe_mode) && mem_we) |-> $past(iss_kind == OP_WRITE, 2)); // R2

  AST_FLOW_WRITE_LAG: assert property (@(posedge clk) disable iff (!rst_n)
    (!pipe_mode && mem_we) |-> $past(iss_kind == OP_WRITE)); // R2

  AST_PIPE_READ_LAG: assert property (@(posedge clk) disable iff (!rst_n)
    (pipe_mode && dq_oe) |-> $past(iss_kind == OP_READ, 3)); // R3

  AST_FLOW_READ_LAG: assert property (@(posedge clk) disable iff (!rst_n)
    (!pipe_mode && dq_oe) |-> $past(iss_kind == OP_READ, 2)); // R3

endmodule

// File: rtl/nt_sram.sv
module nt_sram
  import nt_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int NBYTES = 2,
  parameter int BYTE_W = 9
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     pipe_mode,
  input  logic [ADDR_W-1:0]        addr,
  input  logic                     wr_sel,
  input  logic [NBYTES-1:0]        bw_n,
  input  logic                     sel_a_n,
  input  logic                     sel_b,
  input  logic                     sel_c_n,
  input  logic                     adv,
  input  logic                     lin_order,
  input  logic                     oe_n,
  input  logic                     sleep,
  input  logic [NBYTES*BYTE_W-1:0] dq_in,
  output logic [NBYTES*BYTE_W-1:0] dq_out,
  output logic                     dq_oe
);

  localparam int DATA_W = NBYTES * BYTE_W;

  logic              sel_ok;
  op_kind_e          iss_kind;
  logic [ADDR_W-1:0] iss_addr;
  logic [NBYTES-1:0] iss_bw_n;
  logic [ADDR_W-1:0] mem_ra, mem_wa;
  logic              mem_we;
  logic [NBYTES-1:0] mem_wbe;
  logic [DATA_W-1:0] mem_wd, mem_rd;

  assign sel_ok = !sel_a_n && sel_b && !sel_c_n;

  nt_burst_seq #(.ADDR_W(ADDR_W), .NBYTES(NBYTES)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .sel_ok   (sel_ok),
    .adv      (adv),
    .sleep    (sleep),
    .wr_req   (wr_sel),
    .lin_order(lin_order),
    .addr     (addr),
    .bw_n     (bw_n),
    .iss_kind (iss_kind),
    .iss_addr (iss_addr),
    .iss_bw_n (iss_bw_n)
  );

  nt_xfer_pipe #(.ADDR_W(ADDR_W), .NBYTES(NBYTES), .BYTE_W(BYTE_W)) u_xfer (
    .clk      (clk),
    .rst_n    (rst_n),
    .pipe_mode(pipe_mode),
    .oe_n     (oe_n),
    .sleep    (sleep),
    .iss_kind (iss_kind),
    .iss_addr (iss_addr),
    .iss_bw_n (iss_bw_n),
    .dq_in    (dq_in),
    .mem_rd   (mem_rd),
    .mem_ra   (mem_ra),
    .mem_we   (mem_we),
    .mem_wa   (mem_wa),
    .mem_wbe  (mem_wbe),
    .mem_wd   (mem_wd),
    .dq_out   (dq_out),
    .dq_oe    (dq_oe)
  );

  nt_mem_array #(.ADDR_W(ADDR_W), .NBYTES(NBYTES), .BYTE_W(BYTE_W)) u_mem (
    .clk(clk),
    .we (mem_we),
    .wa (mem_wa),
    .wbe(mem_wbe),
    .wd (mem_wd),
    .ra (mem_ra),
    .rd (mem_rd)
  );

  AST_DESEL_FLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!pipe_mode && !adv && !sel_ok) |=> !mem_we); // R5

  AST_DESEL_PIPE: assert property (@(posedge clk) disable iff (!rst_n)
    (pipe_mode && !adv && !sel_ok) |=> ##1 !mem_we); // R5

  AST_SLEEP_FLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!pipe_mode && sleep) |=> !mem_we); // R11

  AST_SLEEP_PIPE: assert property (@(posedge clk) disable iff (!rst_n)
    (pipe_mode && sleep) |=> ##1 !mem_we); // R11

endmodule

// File: tb/nt_sram_test.sv
module nt_sram_test;

  localparam int AW = 6;
  localparam int DW = 18;

  typedef struct {
    int          due;
    logic [17:0] data;
    string       tag;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          pipe_mode, wr_sel, sel_a_n, sel_b, sel_c_n, adv, lin_order, oe_n, sleep;
  logic [AW-1:0] addr;
  logic [1:0]    bw_n;
  logic [DW-1:0] dq_in, dq_out;
  logic          dq_oe;

  int vectors = 0;
  int fails   = 0;
  int edge_no = 0;
  int lat     = 2;
  bit done    = 0;

  exp_t          expq[$];
  logic [DW-1:0] sched[int];
  logic [DW-1:0] shadow [64];

  // Driver-side knobs
  logic sa_v = 1'b0, sb_v = 1'b1, sc_v = 1'b0, lin_v = 1'b1, oe_v = 1'b0, slp_v = 1'b0;
  // Bench burst model
  bit         b_act = 0;
  bit         b_wr  = 0;
  logic [5:0] b_base = '0;
  logic [1:0] b_cnt  = '0;

  nt_sram uut (
    .clk(clk), .rst_n(rst_n), .pipe_mode(pipe_mode), .addr(addr), .wr_sel(wr_sel),
    .bw_n(bw_n), .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n), .adv(adv),
    .lin_order(lin_order), .oe_n(oe_n), .sleep(sleep), .dq_in(dq_in),
    .dq_out(dq_out), .dq_oe(dq_oe)
  );

  always #2 clk = ~clk;

  always @(posedge clk) edge_no = edge_no + 1;

  function automatic logic [17:0] pat(input int a, input int salt);
    return 18'((a * 1033) ^ (salt * 4211) ^ 18'h2B4C1);
  endfunction

  // kind: 0 idle, 1 new read, 2 new write, 3 advance
  task automatic step(input int kind, input logic [5:0] a, input logic [1:0] bwn,
                      input logic [17:0] d, input string tag);
    int         k;
    logic [5:0] ea;
    bit         go;
    bit         ce_ok;
    @(negedge clk);
    k         = edge_no + 1;
    addr      = a;
    bw_n      = bwn;
    wr_sel    = (kind == 2);
    adv       = (kind == 3);
    sel_a_n   = sa_v;
    sel_b     = (kind == 0) ? 1'b0 : sb_v;
    sel_c_n   = sc_v;
    lin_order = lin_v;
    oe_n      = oe_v;
    sleep     = slp_v;
    dq_in     = sched.exists(k) ? sched[k] : '0;
    ce_ok     = !sa_v && sb_v && !sc_v && (kind != 0);
    go        = 0;
    ea        = a;
    if (slp_v) begin
      b_act = 0;
    end else if (kind == 3) begin
      if (b_act) begin
        b_cnt = b_cnt + 2'd1;
        ea    = {b_base[5:2], lin_v ? (b_base[1:0] + b_cnt) : (b_base[1:0] ^ b_cnt)};
        go    = 1;
      end
    end else if ((kind == 1 || kind == 2) && ce_ok) begin
      b_act  = 1;
      b_wr   = (kind == 2);
      b_base = a;
      b_cnt  = 2'd0;
      go     = 1;
    end else begin
      b_act = 0;
    end
    if (go) begin
      if (b_wr) begin
        for (int b = 0; b < 2; b++)
          if (!bwn[b]) shadow[ea][b*9 +: 9] = d[b*9 +: 9];
        sched[k + lat] = d;
      end else begin
        expq.push_back('{k + lat, shadow[ea], tag});
      end
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, '0, 2'b11, '0, "R12");
  endtask

  // Monitor: compares the bus against the expected queue every cycle.
  always @(negedge clk) begin
    #1;
    if (!done) begin
      bit    exp_on;
      bit    exp_drv;
      string tg;
      exp_on = 0;
      tg     = "R12";
      if (expq.size() > 0 && expq[0].due < edge_no) begin
        fails++;
        $display("FAIL %s: stale expectation due %0d at edge %0d", expq[0].tag, expq[0].due, edge_no);
        void'(expq.pop_front());
      end
      if (expq.size() > 0 && expq[0].due == edge_no) begin
        exp_on = 1;
        tg     = expq[0].tag;
      end
      exp_drv = exp_on && !oe_n && !sleep && rst_n;
      vectors++;
      if (dq_oe !== exp_drv) begin
        fails++;
        $display("FAIL %s: dq_oe=%b expected %b at edge %0d", exp_drv ? tg : (exp_on ? (oe_n ? "R10" : "R11") : "R12"),
                 dq_oe, exp_drv, edge_no);
      end else if (exp_drv) begin
        vectors++;
        if (dq_out !== expq[0].data) begin
          fails++;
          $display("FAIL %s: dq_out=%h expected %h at edge %0d", tg, dq_out, expq[0].data, edge_no);
        end
      end
      if (exp_on) void'(expq.pop_front());
    end
  end

  task automatic do_reset(input logic mode);
    @(negedge clk);
    rst_n     = 1'b0;
    pipe_mode = mode;
    lat       = mode ? 2 : 1;
    sched.delete();
    b_act     = 0;
    repeat (3) @(negedge clk);
    vectors++;
    if (dq_oe !== 1'b0) begin
      fails++;
      $display("FAIL R12: dq_oe=%b expected 0 in reset", dq_oe);
    end
    rst_n = 1'b1;
  endtask

  task automatic suite(input int salt);
    // R1: fill the array with back-to-back writes
    for (int a = 0; a < 64; a++) step(2, 6'(a), 2'b00, pat(a, salt), "R1");
    // R1/R4: alternate directions with no gap, reading writes still in flight
    step(1, 6'd3, 2'b11, '0, "R1");
    step(2, 6'd3, 2'b00, pat(100, salt), "R1");
    step(1, 6'd3, 2'b11, '0, "R4");
    step(2, 6'd5, 2'b00, pat(101, salt), "R1");
    step(1, 6'd5, 2'b11, '0, "R4");
    step(2, 6'd7, 2'b10, pat(102, salt), "R9");
    step(1, 6'd7, 2'b11, '0, "R4");
    step(2, 6'd8, 2'b01, pat(103, salt), "R9");
    step(1, 6'd8, 2'b11, '0, "R9");
    idle(1);
    step(1, 6'd8, 2'b11, '0, "R9");
    idle(4);
    // R5: each select inactive in turn blocks a write and a read
    sa_v = 1'b1; step(2, 6'd9, 2'b00, pat(104, salt), "R5"); step(1, 6'd9, 2'b11, '0, "R5"); sa_v = 1'b0;
    sb_v = 1'b0; step(2, 6'd9, 2'b00, pat(105, salt), "R5"); sb_v = 1'b1;
    sc_v = 1'b1; step(2, 6'd9, 2'b00, pat(106, salt), "R5"); sc_v = 1'b0;
    step(1, 6'd9, 2'b11, '0, "R5");
    idle(4);
    // R6/R8: counting burst from low bits 01, then wrap
    lin_v = 1'b1;
    step(1, 6'h11, 2'b11, '0, "R6");
    for (int i = 0; i < 3; i++) step(3, '0, 2'b11, '0, "R6");
    step(3, '0, 2'b11, '0, "R8");
    step(3, '0, 2'b11, '0, "R8");
    idle(4);
    // R7: XOR burst read, then XOR burst write with byte masks
    lin_v = 1'b0;
    idle(1);
    step(1, 6'h21, 2'b11, '0, "R7");
    for (int i = 0; i < 3; i++) step(3, '0, 2'b11, '0, "R7");
    step(2, 6'h2E, 2'b00, pat(110, salt), "R7");
    step(3, '0, 2'b01, pat(111, salt), "R9");
    step(3, '0, 2'b10, pat(112, salt), "R9");
    step(3, '0, 2'b00, pat(113, salt), "R7");
    idle(1);
    lin_v = 1'b1;
    idle(1);
    step(1, 6'h2C, 2'b11, '0, "R7");
    for (int i = 0; i < 3; i++) step(3, '0, 2'b11, '0, "R9");
    idle(4);
    // R6: selects are not looked at on advance edges
    step(1, 6'h32, 2'b11, '0, "R6");
    sb_v = 1'b0; sa_v = 1'b1;
    for (int i = 0; i < 3; i++) step(3, '0, 2'b11, '0, "R6");
    sb_v = 1'b1; sa_v = 1'b0;
    idle(4);
    // R10: output enable blanks a read in flight
    step(1, 6'd5, 2'b11, '0, "R10");
    oe_v = 1'b1; idle(lat + 2); oe_v = 1'b0;
    step(1, 6'd5, 2'b11, '0, "R10");
    idle(4);
    // R11: sleep blocks accesses, keeps data, ends a burst
    slp_v = 1'b1;
    step(2, 6'd12, 2'b00, pat(120, salt), "R11");
    step(1, 6'd12, 2'b11, '0, "R11");
    idle(1);
    slp_v = 1'b0;
    step(1, 6'd12, 2'b11, '0, "R11");
    step(1, 6'h18, 2'b11, '0, "R11");
    step(3, '0, 2'b11, '0, "R11");
    slp_v = 1'b1; step(3, '0, 2'b11, '0, "R11"); slp_v = 1'b0;
    step(3, '0, 2'b11, '0, "R11");
    step(3, '0, 2'b11, '0, "R11");
    idle(6);
  endtask

  initial begin
    rst_n = 1'b0; pipe_mode = 1'b1; addr = '0; wr_sel = 1'b0; bw_n = 2'b11;
    sel_a_n = 1'b0; sel_b = 1'b0; sel_c_n = 1'b0; adv = 1'b0; lin_order = 1'b1;
    oe_n = 1'b0; sleep = 1'b0; dq_in = '0;
    do_reset(1'b1);
    suite(1);
    do_reset(1'b0);
    suite(2);
    if (expq.size() != 0) begin
      fails++;
      $display("FAIL R3: %0d expected reads never observed", expq.size());
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL R1: watchdog expired, actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

endmodule